// File: doc/BRIEF.md
# Word-Organized Core Plane Controller

This block drives a two-dimensional, word-organized core plane used as register storage. Each stored word has a read drive line, which switches every core of that word to 0 at full current, and a write drive line, which supplies half of the switching current. Each bit position has a shared sense/write line. During a read, that line carries a pulse from every core that flips. During a write, it supplies the other half of the current. A core switches to 1 only when its word-write line and its bit line are both driven. The plane itself is modelled as an array of word registers.

A host issues one request at a time. Each request carries an operation code, a word mask (bit w selects word w) and a data value. The block offers four operations. A single-word read restores the sensed value automatically. A multi-word clear zeroes every masked word. A multi-word write ORs one value into every masked word. A clear-then-write stores an exact value into every masked word. Each operation ends with a one-cycle done strobe.

Top module: `wordcore_ctrl`

## Requirements
- R1: While reset is low and after it is released, `done`, `err` and `busy` are 0 and `rd_data` is 0. Every word of the plane holds 0.
- R2: Op code 0 (read) with exactly one mask bit set returns that word on `rd_data`. `rd_data` is valid while `done` is high, and `done` rises on the third cycle after the request is accepted.
- R3: A read does not change the stored value at the ports: the destroyed word is rewritten with the sensed value, so a second read of the same word returns the same data.
- R4: A read whose mask has zero or several bits set raises `err` together with `done` on the first cycle after acceptance, and leaves every word unchanged.
- R5: Op code 1 (clear) sets every masked word to 0 and leaves unmasked words unchanged. `done` rises on the second cycle after acceptance.
- R6: Op code 2 (write) ORs `req_data` into every masked word in a single write step and leaves unmasked words unchanged. `done` rises on the second cycle after acceptance.
- R7: Op code 3 (clear-then-write) leaves every masked word exactly equal to `req_data`. `done` rises on the third cycle after acceptance.
- R8: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after acceptance through the `done` cycle, then returns to 0.
- R9: A request presented while `busy` is high is ignored and has no effect on any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_op | input | 2 | 0 read, 1 clear, 2 write (OR), 3 clear-then-write |
| req_mask | input | WORDS | Word select, bit w selects word w |
| req_data | input | WIDTH | Value to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| err | output | 1 | Rejected read, valid with `done` |
| rd_data | output | WIDTH | Last sensed word |

## Verification
A wrong sequencer state appears at the ports within a few cycles. It shows as a `done` strobe arriving on the wrong cycle, missing, or lasting two cycles, or as `err` rising on a legal read. A wrong plane state stays hidden until the affected word is read. Every scenario therefore ends with read-back of all words against a model, and each read is repeated so that a missing restore shows on the second read. A request that leaks in while `busy` is high shows only in that read-back.

// File: rtl/wcc_pkg.sv
// Shared types for the word-organized core plane controller.
// Assumes: op code values are fixed by the host interface contract.
package wcc_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_WRITE = 2'd2,
        OP_CLRWR = 2'd3
    } wcc_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ,
        S_RESTORE,
        S_CLEAR,
        S_WRITE,
        S_FINISH
    } wcc_state_e;
endpackage

// File: rtl/wcc_plane.sv
// Behavioural model of the core plane: one register per word.
// Full current on a word-read line switches all cores of that word to 0.
// Half current on a word-write line combined with half current on a bit
// line switches that core to 1 (OR behaviour).
// Assumes: the sequencer never drives read and write lines of a word together.
module wcc_plane #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORDS-1:0]         rd_lines,
    input  logic [WORDS-1:0]         wr_lines,
    input  logic [WIDTH-1:0]         bit_lines,
    output logic [WORDS*WIDTH-1:0]   cells_flat
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WIDTH-1:0] word_q;

        // Switch the cores of one word according to the drive lines.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (rd_lines[w]) begin
                word_q <= '0;
            end else if (wr_lines[w]) begin
                word_q <= word_q | bit_lines;
            end
        end

        assign cells_flat[w*WIDTH +: WIDTH] = word_q;
    end
endmodule

// File: rtl/wcc_sense.sv
// Sense path: each bit line collects a pulse from every core of a
// read-selected word that holds 1 and is about to flip.
// Assumes: the pulse is sampled in the same cycle that the read current flows.
module wcc_sense #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic [WORDS*WIDTH-1:0] cells_flat,
    input  logic [WORDS-1:0]       rd_lines,
    output logic [WIDTH-1:0]       sense
);
    logic [WIDTH-1:0] contrib [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_contrib
        assign contrib[w] = rd_lines[w] ? cells_flat[w*WIDTH +: WIDTH] : '0;
    end

    // OR the flip pulses of all driven words onto the bit lines.
    always_comb begin
        sense = '0;
        for (int w = 0; w < WORDS; w++) begin
            sense = sense | contrib[w];
        end
    end
endmodule

// File: rtl/wcc_seq.sv
// Operation sequencer: accepts one request at a time and steps through
// read/restore, clear, write or clear-then-write, and ends each
// operation with a single finish cycle carrying done (and err).
// Assumes: requests are ignored while busy.
module wcc_seq
    import wcc_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [WORDS-1:0] req_mask,
    input  logic [WIDTH-1:0] req_data,
    input  logic [WIDTH-1:0] sense,
    output logic [WORDS-1:0] rd_lines,
    output logic [WORDS-1:0] wr_lines,
    output logic [WIDTH-1:0] bit_lines,
    output logic [WIDTH-1:0] rd_data,
    output logic             busy,
    output logic             done,
    output logic             err
);
    wcc_state_e       state_q;
    logic [WORDS-1:0] mask_q;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] rd_q;
    logic             then_wr_q;
    logic             err_q;
    wcc_op_e          op_in;

    assign op_in = wcc_op_e'(req_op);

    // Advance the operation state machine and hold the request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            mask_q    <= '0;
            data_q    <= '0;
            rd_q      <= '0;
            then_wr_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        mask_q    <= req_mask;
                        data_q    <= req_data;
                        err_q     <= 1'b0;
                        then_wr_q <= 1'b0;
                        case (op_in)
                            OP_READ: begin
                                if ($onehot(req_mask)) begin
                                    state_q <= S_READ;
                                end else begin
                                    err_q   <= 1'b1;
                                    state_q <= S_FINISH;
                                end
                            end
                            OP_CLEAR: state_q <= S_CLEAR;
                            OP_WRITE: state_q <= S_WRITE;
                            default: begin
                                then_wr_q <= 1'b1;
                                state_q   <= S_CLEAR;
                            end
                        endcase
                    end
                end
                S_READ: begin
                    rd_q    <= sense;
                    state_q <= S_RESTORE;
                end
                S_RESTORE: state_q <= S_FINISH;
                S_CLEAR:   state_q <= then_wr_q ? S_WRITE : S_FINISH;
                S_WRITE:   state_q <= S_FINISH;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    // Drive the word and bit lines from the current step.
    always_comb begin
        rd_lines  = '0;
        wr_lines  = '0;
        bit_lines = '0;
        case (state_q)
            S_READ, S_CLEAR: rd_lines = mask_q;
            S_RESTORE: begin
                wr_lines  = mask_q;
                bit_lines = rd_q;
            end
            S_WRITE: begin
                wr_lines  = mask_q;
                bit_lines = data_q;
            end
            default: ;
        endcase
    end

    assign rd_data = rd_q;
    assign busy    = (state_q != S_IDLE);
    assign done    = (state_q == S_FINISH);
    assign err     = (state_q == S_FINISH) && err_q;
endmodule

// File: rtl/wordcore_ctrl.sv
// Top of the word-organized core plane controller: sequencer, sense
// path and behavioural plane.
// Assumes: synchronous active-low reset; one request in flight at a time.
module wordcore_ctrl #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [WORDS-1:0] req_mask,
    input  logic [WIDTH-1:0] req_data,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [WIDTH-1:0] rd_data
);
    logic [WORDS-1:0]       rd_lines;
    logic [WORDS-1:0]       wr_lines;
    logic [WIDTH-1:0]       bit_lines;
    logic [WIDTH-1:0]       sense;
    logic [WORDS*WIDTH-1:0] cells_flat;

    wcc_seq #(.WORDS(WORDS), .WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mask(req_mask), .req_data(req_data), .sense(sense),
        .rd_lines(rd_lines), .wr_lines(wr_lines), .bit_lines(bit_lines),
        .rd_data(rd_data), .busy(busy), .done(done), .err(err)
    );

    wcc_sense #(.WORDS(WORDS), .WIDTH(WIDTH)) u_sense (
        .cells_flat(cells_flat), .rd_lines(rd_lines), .sense(sense)
    );

    wcc_plane #(.WORDS(WORDS), .WIDTH(WIDTH)) u_plane (
        .clk(clk), .rst_n(rst_n), .rd_lines(rd_lines), .wr_lines(wr_lines),
        .bit_lines(bit_lines), .cells_flat(cells_flat)
    );
endmodule

// File: rtl/wcc_checker.sv
// Protocol checker for wordcore_ctrl, attached by bind.
// Assumes: it sees the top ports and the internal drive lines.
module wcc_checker #(
    parameter int WORDS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic [WORDS-1:0] req_mask,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [WORDS-1:0] rd_lines,
    input logic [WORDS-1:0] wr_lines
);
    // R8: the done strobe never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: err only appears together with done
    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R3: read current and write current never flow in the same cycle
    assert_rd_wr_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !((|rd_lines) && (|wr_lines)));

    // R3: an accepted single-word read rewrites that same word two cycles later
    assert_read_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'd0 && $onehot(req_mask))
        |=> ##1 (wr_lines == $past(req_mask, 2)));

    // R4: a rejected read drives no lines and finishes with err
    assert_bad_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_op == 2'd0 && !$onehot(req_mask))
        |=> (err && rd_lines == '0 && wr_lines == '0));

    // R9: while busy, no new operation starts from idle
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind wordcore_ctrl wcc_checker #(.WORDS(WORDS)) u_wcc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_mask(req_mask), .busy(busy), .done(done), .err(err),
    .rd_lines(rd_lines), .wr_lines(wr_lines)
);

// File: tb/test_wordcore_ctrl.sv
// Directed bench for wordcore_ctrl with a reference model of the words.
module test_wordcore_ctrl;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [1:0]       req_op = 2'd0;
    logic [WORDS-1:0] req_mask = '0;
    logic [WIDTH-1:0] req_data = '0;
    logic             busy, done, err;
    logic [WIDTH-1:0] rd_data;

    logic [WIDTH-1:0] mdl [WORDS];
    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wordcore_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) i_wordcore_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_mask(req_mask), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one request, measure latency to done, check err and the strobe.
    task automatic do_op(input logic [1:0] op, input logic [WORDS-1:0] m,
                         input logic [WIDTH-1:0] d, input int exp_lat,
                         input bit exp_err, input string tag);
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_mask = m; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
        chk(err == exp_err, {tag, " err"}, err, exp_err);
        chk(busy == 1'b1, "R8 busy during done", busy, 1);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
        chk(busy == 1'b0, "R8 busy released", busy, 0);
    endtask

    // Read a word twice (R2 value, R3 restore) and compare with the model.
    task automatic read_word(input int w);
        for (int k = 0; k < 2; k++) begin
            do_op(2'd0, WORDS'(1) << w, '0, 3, 1'b0, "R2 read");
            chk(rd_data == mdl[w], k == 0 ? "R2 read data" : "R3 reread data",
                rd_data, mdl[w]);
        end
    endtask

    task automatic read_all();
        for (int w = 0; w < WORDS; w++) read_word(w);
    endtask

    task automatic t_reset();
        chk(done == 0 && err == 0 && busy == 0, "R1 reset outputs", {done, err, busy}, 0);
        chk(rd_data == '0, "R1 reset rd_data", rd_data, 0);
        for (int w = 0; w < WORDS; w++) mdl[w] = '0;
        read_all();
    endtask

    task automatic t_write_or();
        do_op(2'd2, 8'b1010_0101, 16'h00F0, 2, 1'b0, "R6 write");
        for (int w = 0; w < WORDS; w++) if (w == 0 || w == 2 || w == 5 || w == 7) mdl[w] |= 16'h00F0;
        do_op(2'd2, 8'b0000_0111, 16'h8001, 2, 1'b0, "R6 write");
        for (int w = 0; w < 3; w++) mdl[w] |= 16'h8001;
        read_all();
    endtask

    task automatic t_clear();
        do_op(2'd1, 8'b0000_0110, 16'hFFFF, 2, 1'b0, "R5 clear");
        mdl[1] = '0; mdl[2] = '0;
        read_all();
    endtask

    task automatic t_clrwr();
        do_op(2'd3, 8'b1100_0001, 16'h1234, 3, 1'b0, "R7 clear-write");
        mdl[0] = 16'h1234; mdl[6] = 16'h1234; mdl[7] = 16'h1234;
        do_op(2'd3, 8'b0000_1000, 16'hBEEF, 3, 1'b0, "R7 clear-write");
        mdl[3] = 16'hBEEF;
        read_all();
    endtask

    task automatic t_bad_read();
        do_op(2'd0, 8'b0001_0001, '0, 1, 1'b1, "R4 multi-word read");
        do_op(2'd0, 8'b0000_0000, '0, 1, 1'b1, "R4 empty-mask read");
        read_all();
    endtask

    task automatic t_busy_ignore();
        int lat;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd2; req_mask = 8'b0001_0000; req_data = 16'h0003;
        @(negedge clk);
        req_op = 2'd1; req_mask = 8'hFF; req_data = '0;
        chk(busy == 1'b1, "R9 busy seen", busy, 1);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 2;
        chk(done == 1'b1, "R9 first op done", done, 1);
        @(negedge clk);
        mdl[4] |= 16'h0003;
        read_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && err == 0 && busy == 0, "R1 outputs in reset", {done, err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_or();
        t_clear();
        t_clrwr();
        t_bad_read();
        t_busy_ignore();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule